// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks the even parity bits of a multiplexed 64-bit address/data bus, one parity bit for each 32-bit half. It sees the bus values, the strobe that marks a transaction in progress, the initiator-ready and target-ready strobes, the transfer direction and a role flag. From these it decides, cycle by cycle, whether this side of the bus must present parity or receive it. It also decides which value the parity must cover.

Parity is never combinational. The block captures the parity of the bus in every cycle that qualifies: the address phase, or a data phase cycle in which the strobe that marks valid data is asserted. It then presents that bit in the following cycle, together with an output enable. The enable is raised only when this side is the one that must drive. This is the address phase and write data phases when acting as initiator, and read data phases when acting as target. When this side receives instead, the parity arriving on the bus is compared one cycle later against the captured bit. A mismatch sets a sticky error flag for that half. In narrow (32-bit) mode the upper half is neither driven nor checked.

All strobes at the ports are active high. The byte-enable/command lines are taken at their raw, active-low pin level, and parity is computed over those levels.

Top module: `pci_parity_unit`

## Requirements
- R1: `parity_lo_o` equals the XOR of `bus_data_i[31:0]` and `cmd_ben_i[3:0]`, both taken in the capture cycle, so that the 37 bits together carry an even number of ones.
- R2: `parity_hi_o` equals the XOR of `bus_data_i[63:32]` and `cmd_ben_i[7:4]`, both taken in the capture cycle.
- R3: When `cycle_i` is asserted while no transaction is open (the address phase) and `master_i` is 1, both output enables are 1 in the next cycle and carry the parity of the address phase.
- R4: As initiator on a write (`master_i`=1, `write_i`=1), the enables are 1 in each cycle after a cycle with `init_rdy_i`=1. This keeps parity valid through target wait states and until one cycle after the data phase completes (`init_rdy_i` and `tgt_rdy_i` both 1). A cycle after a cycle with `init_rdy_i`=0 has the enables at 0. The parity outputs keep their value through cycles that capture nothing.
- R5: As target on a read (`master_i`=0, `write_i`=0), the enables are 0 after the address phase and 1 in each cycle after a cycle with `tgt_rdy_i`=1, with the parity of that cycle's bus value.
- R6: The enables are 0 in every cycle in which this side receives parity: after a target address phase, during initiator reads, during target writes, and when idle.
- R7: In a cycle where this side receives parity, a received bit that differs from the captured parity sets that half's error flag, which is visible from the next cycle. A matching bit leaves the flag unchanged.
- R8: An error flag stays 1 until a cycle with `err_clr_i`=1, which clears it from the next cycle. A mismatch in the same cycle as the clear keeps the flag at 1.
- R9: With `wide_i`=0 the upper enable stays 0 and the upper error flag is never set, while the lower half works unchanged.
- R10: While `rst_ni` is 0 and in the first cycle after reset, all enables, parity outputs and error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_data_i | input | 64 | Address/data bus value |
| cmd_ben_i | input | 8 | Command/byte-enable lines, raw active-low level |
| cycle_i | input | 1 | Transaction in progress; deasserted in the final data phase |
| init_rdy_i | input | 1 | Initiator ready |
| tgt_rdy_i | input | 1 | Target ready |
| write_i | input | 1 | 1 = write transfer, 0 = read |
| master_i | input | 1 | 1 = this side is initiator, 0 = target |
| wide_i | input | 1 | 1 = 64-bit bus, 0 = 32-bit bus |
| err_clr_i | input | 1 | Clears both error flags |
| rx_lo_i | input | 1 | Received lower parity bit |
| rx_hi_i | input | 1 | Received upper parity bit |
| parity_lo_o | output | 1 | Lower parity bit |
| parity_lo_oe_o | output | 1 | Lower parity output enable |
| parity_hi_o | output | 1 | Upper parity bit |
| parity_hi_oe_o | output | 1 | Upper parity output enable |
| err_lo_o | output | 1 | Sticky lower parity error |
| err_hi_o | output | 1 | Sticky upper parity error |

## Verification
A stale or wrongly set open-transaction state would show one cycle later. The address phase of the next transaction would then be taken as a data phase, and the enable after it would follow the ready strobes instead of the role flag. A wrong drive/receive decision shows in the very next cycle: an enable that is raised while the bench is supplying parity, or an error flag that rises on a phase the block itself drove. A captured parity bit that is stale or covers the wrong half shows on the parity output in the cycle after capture. On the receive side it shows one cycle later still, as an error flag that disagrees with the flip the bench injected.

// File: rtl/pci_parity_pkg.sv
package pci_parity_pkg;

   // Per-cycle decision for one parity lane, registered by the phase tracker.
   typedef struct packed {
      logic drive;   // this side presents parity this cycle
      logic check;   // this side receives and compares parity this cycle
   } lane_ctl_t;

   localparam lane_ctl_t LANE_IDLE = '{drive: 1'b0, check: 1'b0};

   // Role encodings of the master flag
   typedef enum logic {
      ROLE_TARGET = 1'b0,
      ROLE_INIT   = 1'b1
   } role_e;

endpackage

// File: rtl/pci_parity_tracker.sv
module pci_parity_tracker
   import pci_parity_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      cycle_i,
   input  logic      init_rdy_i,
   input  logic      tgt_rdy_i,
   input  logic      write_i,
   input  logic      master_i,
   output logic      cap_o,
   output lane_ctl_t ctl_o
);

   logic      open_q;
   logic      addr_ph;
   logic      data_done;
   logic      qualify;
   logic      owns_data;
   role_e     role;
   lane_ctl_t ctl_d;

   assign role      = role_e'(master_i);
   assign addr_ph   = cycle_i & ~open_q;
   assign data_done = open_q & init_rdy_i & tgt_rdy_i;
   // The strobe from the side that supplies the data marks valid bus content
   assign qualify   = open_q & (write_i ? init_rdy_i : tgt_rdy_i);
   // Initiator supplies write data, target supplies read data
   assign owns_data = (role == ROLE_INIT) ? write_i : ~write_i;
   assign cap_o     = addr_ph | qualify;

   always_comb begin
      ctl_d = LANE_IDLE;
      if (addr_ph) begin
         ctl_d.drive = (role == ROLE_INIT);
         ctl_d.check = (role == ROLE_TARGET);
      end else if (qualify) begin
         ctl_d.drive = owns_data;
         ctl_d.check = ~owns_data;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         open_q <= 1'b0;
         ctl_o  <= LANE_IDLE;
      end else begin
         if (addr_ph)
            open_q <= 1'b1;
         else if (data_done && !cycle_i)
            open_q <= 1'b0;
         ctl_o <= ctl_d;
      end
   end

endmodule

// File: rtl/pci_parity_lane.sv
module pci_parity_lane
   import pci_parity_pkg::*;
#(
   parameter int HALF_W = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [HALF_W-1:0]   data_i,
   input  logic [HALF_W/8-1:0] ben_i,
   input  logic                en_i,
   input  logic                cap_i,
   input  lane_ctl_t           ctl_i,
   input  logic                rx_i,
   input  logic                err_clr_i,
   output logic                tx_o,
   output logic                oe_o,
   output logic                err_o
);

   localparam int BE_W = HALF_W / 8;

   logic par_q;
   logic err_q;
   logic mismatch;

   // Even parity: the stored bit makes the total count of ones even
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         par_q <= 1'b0;
      else if (cap_i)
         par_q <= ^{data_i, ben_i[BE_W-1:0]};
   end

   assign mismatch = en_i & ctl_i.check & (rx_i != par_q);

   // Set has priority over clear so an error in the clear cycle survives
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         err_q <= 1'b0;
      else if (mismatch)
         err_q <= 1'b1;
      else if (err_clr_i)
         err_q <= 1'b0;
   end

   assign tx_o  = par_q;
   assign oe_o  = en_i & ctl_i.drive;
   assign err_o = err_q;

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
   import pci_parity_pkg::*;
#(
   parameter int HALF_W     = 32,
   parameter int NUM_HALVES = 2,
   localparam int HALF_BE   = HALF_W / 8,
   localparam int BUS_W     = HALF_W * NUM_HALVES,
   localparam int BEN_W     = HALF_BE * NUM_HALVES
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [BUS_W-1:0] bus_data_i,
   input  logic [BEN_W-1:0] cmd_ben_i,
   input  logic             cycle_i,
   input  logic             init_rdy_i,
   input  logic             tgt_rdy_i,
   input  logic             write_i,
   input  logic             master_i,
   input  logic             wide_i,
   input  logic             err_clr_i,
   input  logic             rx_lo_i,
   input  logic             rx_hi_i,
   output logic             parity_lo_o,
   output logic             parity_lo_oe_o,
   output logic             parity_hi_o,
   output logic             parity_hi_oe_o,
   output logic             err_lo_o,
   output logic             err_hi_o
);

   if (NUM_HALVES < 1 || NUM_HALVES > 2) begin : g_bad_halves
      $error("NUM_HALVES must be 1 or 2");
   end
   if (HALF_W < 8 || (HALF_W % 8) != 0) begin : g_bad_width
      $error("HALF_W must be a positive multiple of 8");
   end

   logic                  cap;
   lane_ctl_t             ctl;
   logic [NUM_HALVES-1:0] lane_en;
   logic [NUM_HALVES-1:0] lane_rx;
   logic [NUM_HALVES-1:0] lane_tx;
   logic [NUM_HALVES-1:0] lane_oe;
   logic [NUM_HALVES-1:0] lane_err;

   pci_parity_tracker u_track (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cycle_i    (cycle_i),
      .init_rdy_i (init_rdy_i),
      .tgt_rdy_i  (tgt_rdy_i),
      .write_i    (write_i),
      .master_i   (master_i),
      .cap_o      (cap),
      .ctl_o      (ctl)
   );

   for (genvar h = 0; h < NUM_HALVES; h++) begin : g_lane
      if (h == 0) begin : g_low
         assign lane_en[h] = 1'b1;
         assign lane_rx[h] = rx_lo_i;
      end else begin : g_high
         assign lane_en[h] = wide_i;
         assign lane_rx[h] = rx_hi_i;
      end

      pci_parity_lane #(.HALF_W(HALF_W)) u_lane (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .data_i    (bus_data_i[h*HALF_W +: HALF_W]),
         .ben_i     (cmd_ben_i[h*HALF_BE +: HALF_BE]),
         .en_i      (lane_en[h]),
         .cap_i     (cap),
         .ctl_i     (ctl),
         .rx_i      (lane_rx[h]),
         .err_clr_i (err_clr_i),
         .tx_o      (lane_tx[h]),
         .oe_o      (lane_oe[h]),
         .err_o     (lane_err[h])
      );
   end

   assign parity_lo_o    = lane_tx[0];
   assign parity_lo_oe_o = lane_oe[0];
   assign err_lo_o       = lane_err[0];

   if (NUM_HALVES == 2) begin : g_hi_out
      assign parity_hi_o    = lane_tx[1];
      assign parity_hi_oe_o = lane_oe[1];
      assign err_hi_o       = lane_err[1];
   end else begin : g_hi_none
      assign parity_hi_o    = 1'b0;
      assign parity_hi_oe_o = 1'b0;
      assign err_hi_o       = 1'b0;
   end

endmodule

module pci_parity_unit_chk #(
   parameter int HALF_W     = 32,
   parameter int NUM_HALVES = 2,
   localparam int HALF_BE   = HALF_W / 8,
   localparam int BUS_W     = HALF_W * NUM_HALVES,
   localparam int BEN_W     = HALF_BE * NUM_HALVES
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [BUS_W-1:0] bus_data_i,
   input logic [BEN_W-1:0] cmd_ben_i,
   input logic             cycle_i,
   input logic             init_rdy_i,
   input logic             tgt_rdy_i,
   input logic             wide_i,
   input logic             err_clr_i,
   input logic             parity_lo_o,
   input logic             parity_lo_oe_o,
   input logic             parity_hi_o,
   input logic             parity_hi_oe_o,
   input logic             err_lo_o,
   input logic             err_hi_o
);

   // A driven lower bit covers the bus values of the previous cycle (R1)
   assert_lo_value_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      parity_lo_oe_o |-> (parity_lo_o ==
         ^$past({bus_data_i[HALF_W-1:0], cmd_ben_i[HALF_BE-1:0]})));

   if (NUM_HALVES == 2) begin : g_hi_chk
      assert_hi_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         parity_hi_oe_o |-> (parity_hi_o ==
            ^$past({bus_data_i[BUS_W-1:HALF_W], cmd_ben_i[BEN_W-1:HALF_BE]})));
   end

   // Driving only follows a cycle with some bus activity (R6)
   assert_no_idle_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      parity_lo_oe_o |-> $past(cycle_i || init_rdy_i || tgt_rdy_i));

   // An error never comes from a phase this side drove itself (R7)
   assert_err_on_rx_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_lo_o) |-> !$past(parity_lo_oe_o));

   // Error flags hold until cleared (R8)
   assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_lo_o && !err_clr_i) |=> err_lo_o);

   // Narrow mode never raises the upper error (R9)
   assert_narrow_no_hi_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wide_i && !err_hi_o) |=> !err_hi_o);

   // Upper enable never rises while the bus is narrow (R9)
   assert_narrow_no_hi_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wide_i && $past(!wide_i)) |-> !parity_hi_oe_o);

endmodule

bind pci_parity_unit pci_parity_unit_chk #(
   .HALF_W     (HALF_W),
   .NUM_HALVES (NUM_HALVES)
) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .bus_data_i     (bus_data_i),
   .cmd_ben_i      (cmd_ben_i),
   .cycle_i        (cycle_i),
   .init_rdy_i     (init_rdy_i),
   .tgt_rdy_i      (tgt_rdy_i),
   .wide_i         (wide_i),
   .err_clr_i      (err_clr_i),
   .parity_lo_o    (parity_lo_o),
   .parity_lo_oe_o (parity_lo_oe_o),
   .parity_hi_o    (parity_hi_o),
   .parity_hi_oe_o (parity_hi_oe_o),
   .err_lo_o       (err_lo_o),
   .err_hi_o       (err_hi_o)
);

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] ad = '0;
   logic [7:0]  cbe = '0;
   logic        cyc = 1'b0, irdy = 1'b0, trdy = 1'b0;
   logic        wr = 1'b0, mst = 1'b0, wide = 1'b1, clr = 1'b0;
   logic        rxl = 1'b0, rxh = 1'b0;
   logic        pl, ploe, ph, phoe, el, eh;
   int          total = 0;
   int          bad = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   pci_parity_unit u_dut (
      .clk_i (clk), .rst_ni (rst_n), .bus_data_i (ad), .cmd_ben_i (cbe),
      .cycle_i (cyc), .init_rdy_i (irdy), .tgt_rdy_i (trdy), .write_i (wr),
      .master_i (mst), .wide_i (wide), .err_clr_i (clr), .rx_lo_i (rxl),
      .rx_hi_i (rxh), .parity_lo_o (pl), .parity_lo_oe_o (ploe),
      .parity_hi_o (ph), .parity_hi_oe_o (phoe), .err_lo_o (el), .err_hi_o (eh)
   );

   function automatic logic lo_par(input logic [63:0] a, input logic [7:0] c);
      return ^{a[31:0], c[3:0]};
   endfunction
   function automatic logic hi_par(input logic [63:0] a, input logic [7:0] c);
      return ^{a[63:32], c[7:4]};
   endfunction
   function automatic logic [63:0] pat(input int i);
      logic [31:0] v = 32'(i);
      return {v * 32'h9E37_79B1, (v * 32'h85EB_CA6B) ^ 32'hA5A5_0F0F};
   endfunction

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // Every helper sets inputs, lets one rising edge pass, returns at the next falling edge
   task automatic addr_ph(input logic m, input logic w, input logic [63:0] a, input logic [7:0] c);
      cyc = 1'b1; irdy = 1'b0; trdy = 1'b0; mst = m; wr = w; ad = a; cbe = c;
      @(negedge clk);
   endtask
   task automatic data_cyc(input logic fr, input logic ir, input logic tr,
                           input logic [63:0] d, input logic [7:0] b);
      cyc = fr; irdy = ir; trdy = tr; ad = d; cbe = b;
      @(negedge clk);
   endtask
   task automatic idle();
      cyc = 1'b0; irdy = 1'b0; trdy = 1'b0; ad = 64'hDEAD_BEEF_0BAD_F00D; cbe = 8'h5A;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] a, d, d2;
      logic [7:0]  c, b;
      // R10: reset state
      @(negedge clk);
      chk("R10", "oe_lo in reset", ploe, 1'b0);
      chk("R10", "err_lo in reset", el, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "oe_lo", ploe, 1'b0); chk("R10", "oe_hi", phoe, 1'b0);
      chk("R10", "par_lo", pl, 1'b0); chk("R10", "par_hi", ph, 1'b0);
      chk("R10", "err_lo", el, 1'b0); chk("R10", "err_hi", eh, 1'b0);

      // R1 R2 R3: sweep over every command/byte-enable code, initiator single write
      for (int i = 0; i < 256; i++) begin
         a = pat(i); c = 8'(i); d = pat(i + 1000) ^ {a[31:0], a[63:32]}; b = ~c;
         addr_ph(1'b1, 1'b1, a, c);
         chk("R3", "oe_lo after addr", ploe, 1'b1); chk("R3", "oe_hi after addr", phoe, 1'b1);
         chk("R1", "par_lo addr", pl, lo_par(a, c)); chk("R2", "par_hi addr", ph, hi_par(a, c));
         data_cyc(1'b0, 1'b1, 1'b1, d, b);
         chk("R4", "oe_lo after write", ploe, 1'b1);
         chk("R1", "par_lo data", pl, lo_par(d, b)); chk("R2", "par_hi data", ph, hi_par(d, b));
         idle();
         chk("R6", "oe_lo idle", ploe, 1'b0); chk("R6", "oe_hi idle", phoe, 1'b0);
      end

      // R4: initiator wait, target waits, hold after completion, burst
      for (int w = 0; w < 4; w++) begin
         a = pat(w + 300); d = pat(w + 400); d2 = pat(w + 500);
         addr_ph(1'b1, 1'b1, a, 8'h07);
         chk("R3", "oe_lo addr", ploe, 1'b1);
         data_cyc(1'b1, 1'b0, 1'b0, ~d, 8'hFF);
         chk("R4", "oe_lo after init wait", ploe, 1'b0);
         for (int k = 0; k < w; k++) begin
            data_cyc(1'b1, 1'b1, 1'b0, d, 8'h30);
            chk("R4", "oe_lo in target wait", ploe, 1'b1);
            chk("R4", "par_lo in target wait", pl, lo_par(d, 8'h30));
         end
         data_cyc(1'b1, 1'b1, 1'b1, d, 8'h30);
         chk("R4", "oe_lo after phase 1", ploe, 1'b1);
         chk("R4", "par_lo phase 1", pl, lo_par(d, 8'h30));
         chk("R4", "par_hi phase 1", ph, hi_par(d, 8'h30));
         data_cyc(1'b1, 1'b0, 1'b0, ~d2, 8'hC3);
         chk("R4", "oe_lo after init wait 2", ploe, 1'b0);
         chk("R4", "par_lo held", pl, lo_par(d, 8'h30));
         data_cyc(1'b0, 1'b1, 1'b1, d2, 8'h0C);
         chk("R4", "oe_lo last phase", ploe, 1'b1);
         chk("R4", "par_lo last phase", pl, lo_par(d2, 8'h0C));
         idle();
         chk("R4", "oe_lo released", ploe, 1'b0);
         chk("R4", "par_lo held after end", pl, lo_par(d2, 8'h0C));
      end

      // R5 R6: target read, correct address parity supplied
      for (int i = 0; i < 32; i++) begin
         a = pat(i + 600); d = pat(i + 700); c = 8'(i * 37);
         addr_ph(1'b0, 1'b0, a, c);
         chk("R5", "oe_lo after target addr", ploe, 1'b0);
         chk("R5", "oe_hi after target addr", phoe, 1'b0);
         rxl = lo_par(a, c); rxh = hi_par(a, c);
         data_cyc(1'b0, 1'b1, 1'b0, ~d, 8'hAA);
         chk("R5", "oe_lo before tgt ready", ploe, 1'b0);
         rxl = 1'b0; rxh = 1'b0;
         data_cyc(1'b0, 1'b1, 1'b1, d, ~c);
         chk("R5", "oe_lo read data", ploe, 1'b1); chk("R5", "oe_hi read data", phoe, 1'b1);
         chk("R5", "par_lo read data", pl, lo_par(d, ~c));
         chk("R5", "par_hi read data", ph, hi_par(d, ~c));
         idle();
         chk("R5", "oe_lo after read", ploe, 1'b0);
         chk("R7", "no err on good addr lo", el, 1'b0);
         chk("R7", "no err on good addr hi", eh, 1'b0);
      end

      // R6 R7 R8: initiator read with every flip combination, then clear
      for (int f = 0; f < 4; f++) begin
         a = pat(f + 800); d = pat(f + 900);
         addr_ph(1'b1, 1'b0, a, 8'h06);
         chk("R3", "oe_lo read addr", ploe, 1'b1);
         data_cyc(1'b0, 1'b1, 1'b1, d, 8'h00);
         chk("R6", "oe_lo initiator read", ploe, 1'b0);
         chk("R6", "oe_hi initiator read", phoe, 1'b0);
         rxl = lo_par(d, 8'h00) ^ f[0]; rxh = hi_par(d, 8'h00) ^ f[1];
         idle();
         rxl = 1'b0; rxh = 1'b0;
         chk("R7", "err_lo after compare", el, f[0]);
         chk("R7", "err_hi after compare", eh, f[1]);
         clr = 1'b1; idle(); clr = 1'b0;
         chk("R8", "err_lo cleared", el, 1'b0); chk("R8", "err_hi cleared", eh, 1'b0);
      end

      // R8: sticky across a clean transfer, set wins over clear
      a = pat(1100); d = pat(1101);
      addr_ph(1'b1, 1'b0, a, 8'h06);
      data_cyc(1'b0, 1'b1, 1'b1, d, 8'h00);
      rxl = ~lo_par(d, 8'h00); rxh = hi_par(d, 8'h00);
      idle();
      chk("R7", "err_lo set", el, 1'b1);
      rxl = 1'b0; rxh = 1'b0;
      addr_ph(1'b1, 1'b0, a, 8'h06);
      data_cyc(1'b0, 1'b1, 1'b1, d, 8'h00);
      rxl = lo_par(d, 8'h00); rxh = hi_par(d, 8'h00);
      idle();
      chk("R8", "err_lo sticky", el, 1'b1);
      addr_ph(1'b1, 1'b0, a, 8'h06);
      data_cyc(1'b0, 1'b1, 1'b1, d, 8'h00);
      rxl = ~lo_par(d, 8'h00); clr = 1'b1;
      idle();
      clr = 1'b0; rxl = 1'b0; rxh = 1'b0;
      chk("R8", "set beats clear", el, 1'b1);
      clr = 1'b1; idle(); clr = 1'b0;
      chk("R8", "err_lo cleared alone", el, 1'b0);

      // R6 R7: target write receives address and data parity
      a = pat(1200); d = pat(1201);
      addr_ph(1'b0, 1'b1, a, 8'h07);
      chk("R6", "oe_lo target write addr", ploe, 1'b0);
      rxl = lo_par(a, 8'h07); rxh = hi_par(a, 8'h07);
      data_cyc(1'b0, 1'b1, 1'b1, d, 8'h00);
      chk("R6", "oe_lo target write data", ploe, 1'b0);
      chk("R7", "good addr keeps err_lo", el, 1'b0);
      rxl = lo_par(d, 8'h00); rxh = ~hi_par(d, 8'h00);
      idle();
      rxl = 1'b0; rxh = 1'b0;
      chk("R6", "oe_hi target write", phoe, 1'b0);
      chk("R7", "err_lo good data", el, 1'b0);
      chk("R7", "err_hi bad data", eh, 1'b1);
      clr = 1'b1; idle(); clr = 1'b0;

      // R9: narrow bus
      wide = 1'b0;
      for (int i = 0; i < 16; i++) begin
         a = pat(i + 1300); d = pat(i + 1400);
         addr_ph(1'b1, 1'b1, a, 8'(i));
         chk("R9", "oe_hi narrow addr", phoe, 1'b0);
         chk("R9", "oe_lo narrow addr", ploe, 1'b1);
         chk("R1", "par_lo narrow addr", pl, lo_par(a, 8'(i)));
         data_cyc(1'b0, 1'b1, 1'b1, d, 8'(~i));
         chk("R9", "oe_hi narrow data", phoe, 1'b0);
         chk("R1", "par_lo narrow data", pl, lo_par(d, 8'(~i)));
         idle();
         addr_ph(1'b1, 1'b0, a, 8'h06);
         data_cyc(1'b0, 1'b1, 1'b1, d, 8'h00);
         rxl = ~lo_par(d, 8'h00); rxh = ~hi_par(d, 8'h00);
         idle();
         rxl = 1'b0; rxh = 1'b0;
         chk("R9", "err_hi never in narrow", eh, 1'b0);
         chk("R9", "err_lo still checked", el, 1'b1);
         clr = 1'b1; idle(); clr = 1'b0;
      end
      wide = 1'b1;

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule